// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a burst-capable synchronous memory. A cycle starts when one of two active-low start strobes is sampled low at a rising clock edge. At that edge the block captures the external address and decides, from three chip enables, whether the memory is selected or deselected. The processor-side strobe only acts when the main enable is low, and it always begins a read. The controller-side strobe begins a read or a write, as the write input requests.

Between starts, the advance input moves the burst forward. When it is low, the two lowest address bits step to the next beat. When it is high, the address is held for a wait cycle. The upper address bits keep their captured value for the whole burst. A static order input chooses how the beats run. Linear order counts upward modulo four from the captured offset. Interleaved order XORs the captured offset with the beat number. After four beats the burst returns to the captured offset and never carries into the upper bits. The write indication is refreshed on every continue and wait cycle. This lets a read started by the processor strobe turn into a write on the following wait cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `selected`=0, `is_write`=0 and `cur_addr`=0.
- R2: If `start_proc_n`=0 and `en_main_n`=0 at an edge, and also `en_aux_n`=0 and `en_aux`=1, then after that edge `cur_addr` equals the sampled `addr_in`, `selected`=1 and `is_write`=0, whatever the value of `wr_n`.
- R3: When `en_main_n`=1, `start_proc_n` has no effect: the cycle is decided by `start_ctrl_n` and `advance_n` alone.
- R4: If `start_ctrl_n`=0, the processor strobe is not acting and all three enables are active, then after the edge `cur_addr` equals the sampled `addr_in`, `selected`=1 and `is_write` equals the inverse of the sampled `wr_n`.
- R5: An acting start strobe while any enable is inactive deselects the memory: after the edge `selected`=0 and `is_write`=0.
- R6: With `order_interleave`=0, each advance cycle (no acting strobe, `advance_n`=0) while selected sets `cur_addr[1:0]` to its previous value plus one, modulo 4. For example, 01 goes to 10, then 11, then 00.
- R7: With `order_interleave`=1, `cur_addr[1:0]` equals the captured offset XOR the number of advances since the start, modulo 4. For example, 10 goes to 11, then 00, then 01.
- R8: A wait cycle (no acting strobe, `advance_n`=1) while selected leaves `cur_addr` unchanged.
- R9: Advances never change `cur_addr[ADDR_W-1:2]`. After four advances the low bits return to the captured offset.
- R10: Continue and wait cycles while selected set `is_write` to the inverse of the sampled `wr_n`, even when `en_main_n`=1.
- R11: While deselected, cycles with no acting strobe keep `selected`=0, `is_write`=0 and `cur_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address captured at a start |
| start_proc_n | input | 1 | Processor start strobe, active low; gated by `en_main_n` |
| start_ctrl_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low; high means wait |
| en_main_n | input | 1 | Main chip enable, active low |
| en_aux_n | input | 1 | Second chip enable, active low |
| en_aux | input | 1 | Third chip enable, active high |
| wr_n | input | 1 | Combined write request, active low |
| order_interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| cur_addr | output | ADDR_W | Current burst address |
| selected | output | 1 | Memory selected for the current cycle |
| is_write | output | 1 | Current cycle is a write |

## Verification
The bound checker examines every cycle for several behaviours:
- start captures, with their read or write choice;
- deselection when an enable is missing;
- address hold on waits and while deselected;
- the plus-one step in linear order, and the flip of bit 0 on each interleaved step;
- the upper bits staying fixed during advances.

The full interleaved sequence, the return to the captured offset after four beats, the processor strobe being ignored behind an inactive main enable, and the read-then-write-on-wait pattern depend on history over several cycles. Only the bench's directed scenarios and its cycle-by-cycle reference model show these.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        CYC_START_RD  = 3'd0,
        CYC_START_CTL = 3'd1,
        CYC_DESEL     = 3'd2,
        CYC_STEP      = 3'd3,
        CYC_WAIT      = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      wr;
    } cyc_cmd_t;

    // Low address bits of the current beat for either burst order.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        logic [BEAT_W-1:0] r;
        if (interleave) r = base ^ beat;
        else            r = base + beat;
        return r;
    endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  logic     start_proc_n,
    input  logic     start_ctrl_n,
    input  logic     advance_n,
    input  logic     en_main_n,
    input  logic     en_aux_n,
    input  logic     en_aux,
    input  logic     wr_n,
    output cyc_cmd_t cmd
);
    logic all_enabled;

    always_comb begin
        all_enabled = !en_main_n && !en_aux_n && en_aux;
        cmd.wr      = 1'b0;
        if (!start_proc_n && !en_main_n) begin
            // processor start: always a read
            cmd.kind = all_enabled ? CYC_START_RD : CYC_DESEL;
        end else if (!start_ctrl_n) begin
            cmd.kind = all_enabled ? CYC_START_CTL : CYC_DESEL;
            cmd.wr   = all_enabled && !wr_n;
        end else begin
            cmd.kind = advance_n ? CYC_WAIT : CYC_STEP;
            cmd.wr   = !wr_n;
        end
    end
endmodule

// File: rtl/bseq_state.sv
module bseq_state
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cyc_cmd_t                 cmd,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] upper_q,
    output logic [BEAT_W-1:0]        base_q,
    output logic [BEAT_W-1:0]        beat_q,
    output logic                     sel_q,
    output logic                     wr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            base_q  <= '0;
            beat_q  <= '0;
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            case (cmd.kind)
                CYC_START_RD, CYC_START_CTL: begin
                    upper_q <= addr_in[ADDR_W-1:BEAT_W];
                    base_q  <= addr_in[BEAT_W-1:0];
                    beat_q  <= '0;
                    sel_q   <= 1'b1;
                    wr_q    <= cmd.wr;
                end
                CYC_DESEL: begin
                    sel_q <= 1'b0;
                    wr_q  <= 1'b0;
                end
                CYC_STEP: begin
                    if (sel_q) begin
                        beat_q <= beat_q + 1'b1;
                        wr_q   <= cmd.wr;
                    end
                end
                default: begin
                    if (sel_q) wr_q <= cmd.wr;
                end
            endcase
        end
    end
endmodule

// File: rtl/bseq_addr_out.sv
module bseq_addr_out
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-BEAT_W-1:0] upper_q,
    input  logic [BEAT_W-1:0]        base_q,
    input  logic [BEAT_W-1:0]        beat_q,
    input  logic                     interleave,
    output logic [ADDR_W-1:0]        addr_out
);
    always_comb begin
        addr_out = {upper_q, beat_offset(base_q, beat_q, interleave)};
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_proc_n,
    input  logic              start_ctrl_n,
    input  logic              advance_n,
    input  logic              en_main_n,
    input  logic              en_aux_n,
    input  logic              en_aux,
    input  logic              wr_n,
    input  logic              order_interleave,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              selected,
    output logic              is_write
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    cyc_cmd_t           cmd;
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  base_q;
    logic [BEAT_W-1:0]  beat_q;

    bseq_decode u_decode (
        .start_proc_n (start_proc_n),
        .start_ctrl_n (start_ctrl_n),
        .advance_n    (advance_n),
        .en_main_n    (en_main_n),
        .en_aux_n     (en_aux_n),
        .en_aux       (en_aux),
        .wr_n         (wr_n),
        .cmd          (cmd)
    );

    bseq_state #(.ADDR_W(ADDR_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_in (addr_in),
        .upper_q (upper_q),
        .base_q  (base_q),
        .beat_q  (beat_q),
        .sel_q   (selected),
        .wr_q    (is_write)
    );

    bseq_addr_out #(.ADDR_W(ADDR_W)) u_out (
        .upper_q    (upper_q),
        .base_q     (base_q),
        .beat_q     (beat_q),
        .interleave (order_interleave),
        .addr_out   (cur_addr)
    );
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              start_proc_n,
    input logic              start_ctrl_n,
    input logic              advance_n,
    input logic              en_main_n,
    input logic              en_aux_n,
    input logic              en_aux,
    input logic              wr_n,
    input logic              order_interleave,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              selected,
    input logic              is_write
);
    logic all_en, proc_act, ctrl_act, no_start;
    assign all_en   = !en_main_n && !en_aux_n && en_aux;
    assign proc_act = !start_proc_n && !en_main_n;
    assign ctrl_act = !start_ctrl_n && !proc_act;
    assign no_start = !proc_act && start_ctrl_n;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!selected && !is_write && cur_addr == '0));

    assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
        (proc_act && all_en) |=> (selected && !is_write && cur_addr == $past(addr_in)));

    assert_ctrl_start_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_act && all_en) |=> (selected && cur_addr == $past(addr_in) && is_write == !$past(wr_n)));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        ((proc_act || ctrl_act) && !all_en) |=> (!selected && !is_write));

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
        (selected && no_start && !advance_n && !order_interleave)
        |=> (order_interleave || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    assert_interleave_step_R7: assert property (@(posedge clk) disable iff (rst)
        (selected && no_start && !advance_n && order_interleave)
        |=> (!order_interleave || cur_addr[0] != $past(cur_addr[0])));

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (selected && no_start && advance_n)
        |=> (cur_addr == $past(cur_addr) || order_interleave != $past(order_interleave)));

    assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
        (selected && no_start) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    assert_cont_write_R10: assert property (@(posedge clk) disable iff (rst)
        (selected && no_start) |=> (selected && is_write == !$past(wr_n)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!selected && no_start)
        |=> (!selected && !is_write
             && (cur_addr == $past(cur_addr) || order_interleave != $past(order_interleave))));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .addr_in          (addr_in),
    .start_proc_n     (start_proc_n),
    .start_ctrl_n     (start_ctrl_n),
    .advance_n        (advance_n),
    .en_main_n        (en_main_n),
    .en_aux_n         (en_aux_n),
    .en_aux           (en_aux),
    .wr_n             (wr_n),
    .order_interleave (order_interleave),
    .cur_addr         (cur_addr),
    .selected         (selected),
    .is_write         (is_write)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          start_proc_n = 1'b1, start_ctrl_n = 1'b1, advance_n = 1'b1;
    logic          en_main_n = 1'b1, en_aux_n = 1'b1, en_aux = 1'b0;
    logic          wr_n = 1'b1, order_interleave = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          selected, is_write;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    // reference model state
    int  m_sel = 0, m_wr = 0, m_load = 0, m_beats = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n),
        .advance_n(advance_n), .en_main_n(en_main_n), .en_aux_n(en_aux_n),
        .en_aux(en_aux), .wr_n(wr_n), .order_interleave(order_interleave),
        .cur_addr(cur_addr), .selected(selected), .is_write(is_write)
    );

    function automatic int exp_addr();
        int off, low;
        off = m_load % 4;
        if (order_interleave) low = off ^ (m_beats % 4);
        else                  low = (off + m_beats) % 4;
        return (m_load / 4) * 4 + low;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit en_all;
        en_all = (en_main_n == 0) && (en_aux_n == 0) && (en_aux == 1);
        if (rst) begin
            m_sel = 0; m_wr = 0; m_load = 0; m_beats = 0;
        end else if (start_proc_n == 0 && en_main_n == 0) begin
            if (en_all) begin m_sel = 1; m_wr = 0; m_load = int'(addr_in); m_beats = 0; end
            else begin m_sel = 0; m_wr = 0; end
        end else if (start_ctrl_n == 0) begin
            if (en_all) begin m_sel = 1; m_wr = (wr_n == 0); m_load = int'(addr_in); m_beats = 0; end
            else begin m_sel = 0; m_wr = 0; end
        end else if (m_sel == 1) begin
            if (advance_n == 0) m_beats++;
            m_wr = (wr_n == 0);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic cyc(input logic p, input logic c, input logic a,
                       input logic e0, input logic e1, input logic e2,
                       input logic w, input int adr, input string tag);
        @(negedge clk);
        start_proc_n = p; start_ctrl_n = c; advance_n = a;
        en_main_n = e0; en_aux_n = e1; en_aux = e2; wr_n = w;
        addr_in = AW'(adr);
        @(posedge clk);
        model_update();
        #1;
        check({tag, " selected"}, int'(selected), m_sel);
        check({tag, " is_write"}, int'(is_write), m_wr);
        check({tag, " cur_addr"}, int'(cur_addr), exp_addr());
    endtask

    initial begin
        #(50000 * 5);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1 reset
        cyc(1,1,1,1,1,0,1,'h3FFFF,"R1 reset");
        cyc(1,1,1,1,1,0,1,'h3FFFF,"R1 reset");
        check("R1 selected low", int'(selected), 0);
        check("R1 addr zero", int'(cur_addr), 0);
        @(negedge clk); rst = 1'b0;

        // R2 processor start, write inputs low yet read; linear from offset 01
        order_interleave = 1'b0;
        cyc(0,1,1,0,0,1,0,'h12341,"R2 proc start");
        check("R2 read despite wr", int'(is_write), 0);
        cyc(1,1,0,0,0,1,1,'h0,"R6 step");
        check("R6 linear 10", int'(cur_addr[1:0]), 2);
        cyc(1,1,0,0,0,1,1,'h0,"R6 step");
        check("R6 linear 11", int'(cur_addr[1:0]), 3);
        cyc(1,1,0,0,0,1,1,'h0,"R6 step");
        check("R6 linear 00", int'(cur_addr[1:0]), 0);
        check("R9 upper kept", int'(cur_addr[AW-1:2]), 'h12341 >> 2);
        cyc(1,1,0,0,0,1,1,'h0,"R9 wrap");
        check("R9 wrap to offset", int'(cur_addr), 'h12341);

        // R8 wait, then R10 write on wait after a processor read
        cyc(1,1,1,0,0,1,1,'h0,"R8 wait");
        check("R8 hold", int'(cur_addr), 'h12341);
        cyc(1,1,1,0,0,1,0,'h0,"R10 write on wait");
        check("R10 write on wait", int'(is_write), 1);

        // R3 + R10: processor strobe behind inactive main enable is ignored
        cyc(0,1,0,1,0,1,1,'h2AAAA,"R3 ignored proc");
        check("R3 addr not reloaded", int'(cur_addr), 'h12342);
        check("R10 continues with main enable high", int'(selected), 1);

        // R7 interleaved from offset 10: 10,11,00,01
        order_interleave = 1'b1;
        cyc(1,0,1,0,0,1,1,'h00A6,"R4 ctrl read");
        check("R4 ctrl read", int'(is_write), 0);
        cyc(1,1,0,0,0,1,1,'h0,"R7 step");
        check("R7 interleaved 11", int'(cur_addr[1:0]), 3);
        cyc(1,1,0,0,0,1,1,'h0,"R7 step");
        check("R7 interleaved 00", int'(cur_addr[1:0]), 0);
        cyc(1,1,0,0,0,1,1,'h0,"R7 step");
        check("R7 interleaved 01", int'(cur_addr[1:0]), 1);
        cyc(1,1,0,0,0,1,1,'h0,"R9 wrap");
        check("R9 interleaved wrap", int'(cur_addr), 'h00A6);

        // R4 controller write start
        cyc(1,0,1,0,0,1,0,'h3C003,"R4 ctrl write");
        check("R4 ctrl write", int'(is_write), 1);

        // R5 deselect via each enable
        cyc(1,0,1,0,0,0,0,'h1,"R5 ctrl aux high off");
        check("R5 deselect", int'(selected), 0);
        cyc(1,0,1,0,0,1,0,'h5,"R4 reselect");
        cyc(0,1,1,0,1,1,1,'h9,"R5 proc aux low off");
        check("R5 proc deselect", int'(selected), 0);
        cyc(1,0,1,0,0,1,1,'h5,"R4 reselect");
        cyc(0,0,1,1,0,1,0,'h9,"R5 ctrl main off");
        check("R5 main deselect", int'(selected), 0);

        // R11 idle while deselected
        cyc(1,1,0,0,0,1,0,'h7,"R11 idle step");
        cyc(1,1,1,0,0,1,0,'h7,"R11 idle wait");
        check("R11 stays deselected", int'(selected), 0);
        check("R11 no write", int'(is_write), 0);

        // Random traffic against the reference model (all requirements)
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) begin
                @(negedge clk);
                order_interleave = $urandom_range(0, 1);
            end
            cyc(($urandom_range(0,3) != 0), ($urandom_range(0,3) != 0),
                $urandom_range(0,1), ($urandom_range(0,4) == 0),
                ($urandom_range(0,5) == 0), ($urandom_range(0,5) != 0),
                $urandom_range(0,1), int'($urandom_range(0, (1 << AW) - 1)),
                "R2..R11 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule